// File: doc/BRIEF.md
# HDB3/AMI Line Decoder with Code Error Flag

This block sits behind a line receiver and a clock recovery circuit. It takes the two unipolar rail signals that were split from a ternary line, one for positive pulses and one for negative pulses, and samples them on the rising edge of the recovered receive clock. It rebuilds the NRZ bit stream and raises an error flag for each received bit that breaks the coding rules. In HDB3 mode it finds the four-bit substitution groups and returns them to zeros. In AMI mode nothing is substituted, so every polarity violation is an error.

A combinational receive-clock indication output is the OR of the two rails that are in use. A clock recovery circuit outside the block can lock to it. When the loop-test input is high, the block decodes the internal encoder's two outputs and ignores the external rails.

Two small state machines track line polarity. The line-polarity machine has the states LN_START, LN_POS and LN_NEG. It starts in LN_START after reset. A single-rail pulse on the positive rail moves it to LN_POS, and one on the negative rail moves it to LN_NEG. A sample with no pulse, or with both rails high, keeps the state. The violation-memory machine has the states VM_NONE, VM_POS and VM_NEG. It starts in VM_NONE. A polarity violation moves it to VM_POS or VM_NEG according to the polarity of that pulse, and any other sample keeps the state.

Top module: `hdb3_rx_decoder`

## Requirements
- R1: A bit sampled on a rising clock edge appears on `nrz_out` after the fourth rising edge that follows that sampling edge. `err_out` for that bit appears in the same cycle.
- R2: A sample with exactly one rail high is a mark and decodes as 1, unless R3 removes it. A sample with both rails low decodes as 0.
- R3: In HDB3 mode (`hdb3_mode`=1), a violation is a single-rail pulse with the same polarity as the previous single-rail pulse. The window check looks at the four samples before the violation. It passes when the oldest of them is a mark and the two newest are spaces. When the check passes, the violation and the three samples before it all decode as 0. So B000V and BB00V both give 1 followed by four 0s.
- R4: In HDB3 mode, a violation with the same polarity as the previous violation sets `err_out` to 1 for the one cycle of that bit. Other bits from a valid HDB3 stream leave `err_out` at 0.
- R5: In HDB3 mode, a violation that fails the window check decodes as 1 and zeroes nothing. It raises `err_out` only when R4 applies.
- R6: A sample with both rails high decodes as 1 and sets `err_out` for that bit. It does not change either polarity memory.
- R7: In AMI mode (`hdb3_mode`=0), every violation decodes as 1 with `err_out` set, and no group is ever zeroed.
- R8: `rclk_ind` is the combinational OR of the two rails in use.
- R9: With `loop_en`=1, `loop_pos` and `loop_neg` take the place of `pos_rail` and `neg_rail` for both decoding and `rclk_ind`. The external rails then have no effect.
- R10: While `rst_n` is low, `nrz_out` and `err_out` are 0. Both polarity memories start empty, so the first pulse after reset is never a violation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Recovered receive clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| hdb3_mode | input | 1 | 1 selects HDB3 decoding, 0 selects AMI decoding |
| loop_en | input | 1 | 1 decodes the loop inputs instead of the external rails |
| pos_rail | input | 1 | External positive-pulse rail |
| neg_rail | input | 1 | External negative-pulse rail |
| loop_pos | input | 1 | Internal encoder positive output (loop test) |
| loop_neg | input | 1 | Internal encoder negative output (loop test) |
| nrz_out | output | 1 | Decoded NRZ data |
| err_out | output | 1 | Coding error flag, aligned with `nrz_out` |
| rclk_ind | output | 1 | OR of the selected rails |

## Verification
Only `rclk_ind` is combinational. The bench checks it 1 ns after each new rail value is driven on the falling edge. A symbol driven before rising edge k gives its `nrz_out` and `err_out` after edge k+4. The bench therefore compares symbol j-5 at the falling edge where it drives symbol j, and a directed single pulse shows the result in exactly that cycle and in no other. Expected data comes from the NRZ that a bench encoder turned into HDB3, or, for hand-built faulty streams, from a bench reference model of the requirements.

// File: rtl/hdb3_dec_pkg.sv
package hdb3_dec_pkg;

    // Number of symbols in one substitution group; also the decode latency.
    localparam int unsigned GROUP_LEN = 4;

    typedef enum logic [1:0] {
        LN_START = 2'd0,
        LN_POS   = 2'd1,
        LN_NEG   = 2'd2
    } line_pol_e;

    typedef enum logic [1:0] {
        VM_NONE = 2'd0,
        VM_POS  = 2'd1,
        VM_NEG  = 2'd2
    } viol_mem_e;

    // One sampled line symbol.
    typedef struct packed {
        logic mark;   // at least one rail high
        logic both;   // both rails high
        logic pos;    // positive rail high
    } rail_sym_t;

endpackage

// File: rtl/hdb3_rail_in.sv
module hdb3_rail_in
    import hdb3_dec_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      loop_en,
    input  logic      ext_pos,
    input  logic      ext_neg,
    input  logic      lb_pos,
    input  logic      lb_neg,
    output logic      rclk_ind,
    output rail_sym_t sym_q
);

    logic p_sel;
    logic n_sel;

    // Source select for loop test.
    assign p_sel    = loop_en ? lb_pos : ext_pos;
    assign n_sel    = loop_en ? lb_neg : ext_neg;
    assign rclk_ind = p_sel | n_sel;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sym_q <= '0;
        end else begin
            sym_q.mark <= p_sel | n_sel;
            sym_q.both <= p_sel & n_sel;
            sym_q.pos  <= p_sel;
        end
    end

endmodule

// File: rtl/hdb3_pol_fsm.sv
module hdb3_pol_fsm
    import hdb3_dec_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      hdb3_mode,
    input  rail_sym_t sym,
    input  logic      window_ok,
    output logic      subst,
    output logic      err_bit
);

    line_pol_e line_q, line_d;
    viol_mem_e vmem_q, vmem_d;

    logic single;
    logic is_viol;
    logic rep_viol;

    assign single = sym.mark & ~sym.both;

    // State registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_q <= LN_START;
            vmem_q <= VM_NONE;
        end else begin
            line_q <= line_d;
            vmem_q <= vmem_d;
        end
    end

    // Next state and classification outputs.
    always_comb begin
        is_viol  = 1'b0;
        rep_viol = 1'b0;
        unique case (line_q)
            LN_START: is_viol = 1'b0;
            LN_POS:   is_viol = single &  sym.pos;
            LN_NEG:   is_viol = single & ~sym.pos;
            default:  is_viol = 1'b0;
        endcase

        unique case (vmem_q)
            VM_NONE: rep_viol = 1'b0;
            VM_POS:  rep_viol = is_viol &  sym.pos;
            VM_NEG:  rep_viol = is_viol & ~sym.pos;
            default: rep_viol = 1'b0;
        endcase

        line_d = line_q;
        if (single) begin
            line_d = sym.pos ? LN_POS : LN_NEG;
        end

        vmem_d = vmem_q;
        if (is_viol) begin
            vmem_d = sym.pos ? VM_POS : VM_NEG;
        end

        subst   = hdb3_mode & is_viol & window_ok;
        err_bit = sym.both | (hdb3_mode ? rep_viol : is_viol);
    end

endmodule

// File: rtl/hdb3_subst_window.sv
module hdb3_subst_window #(
    parameter int unsigned GLEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mark,
    input  logic subst,
    input  logic err_bit,
    output logic window_ok,
    output logic nrz_out,
    output logic err_out
);

    localparam int unsigned ZLEN = GLEN - 2;  // spaces needed before the violation

    logic [GLEN:1] hist_q;   // raw marks, [1] newest
    logic [GLEN:1] data_q;   // decoded data, [GLEN] on the output
    logic [GLEN:1] flag_q;   // error flags aligned with data_q

    // Oldest history bit must be a mark, the ZLEN newest must be spaces.
    assign window_ok = hist_q[GLEN] & ~(|hist_q[ZLEN:1]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_q <= '0;
            data_q <= '0;
            flag_q <= '0;
        end else begin
            hist_q <= {hist_q[GLEN-1:1], mark};
            flag_q <= {flag_q[GLEN-1:1], err_bit};
            if (subst) begin
                data_q <= '0;
            end else begin
                data_q <= {data_q[GLEN-1:1], mark};
            end
        end
    end

    assign nrz_out = data_q[GLEN];
    assign err_out = flag_q[GLEN];

endmodule

// File: rtl/hdb3_rx_decoder.sv
module hdb3_rx_decoder #(
    parameter int unsigned GLEN = hdb3_dec_pkg::GROUP_LEN
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hdb3_mode,
    input  logic loop_en,
    input  logic pos_rail,
    input  logic neg_rail,
    input  logic loop_pos,
    input  logic loop_neg,
    output logic nrz_out,
    output logic err_out,
    output logic rclk_ind
);

    hdb3_dec_pkg::rail_sym_t sym;
    logic window_ok;
    logic subst;
    logic err_bit;

    hdb3_rail_in u_rail (
        .clk      (clk),
        .rst_n    (rst_n),
        .loop_en  (loop_en),
        .ext_pos  (pos_rail),
        .ext_neg  (neg_rail),
        .lb_pos   (loop_pos),
        .lb_neg   (loop_neg),
        .rclk_ind (rclk_ind),
        .sym_q    (sym)
    );

    hdb3_pol_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .hdb3_mode (hdb3_mode),
        .sym       (sym),
        .window_ok (window_ok),
        .subst     (subst),
        .err_bit   (err_bit)
    );

    hdb3_subst_window #(.GLEN(GLEN)) u_win (
        .clk       (clk),
        .rst_n     (rst_n),
        .mark      (sym.mark),
        .subst     (subst),
        .err_bit   (err_bit),
        .window_ok (window_ok),
        .nrz_out   (nrz_out),
        .err_out   (err_out)
    );

endmodule

// File: rtl/hdb3_rx_decoder_chk.sv
module hdb3_rx_decoder_chk (
    input logic clk,
    input logic rst_n,
    input logic loop_en,
    input logic pos_rail,
    input logic neg_rail,
    input logic loop_pos,
    input logic loop_neg,
    input logic nrz_out,
    input logic err_out,
    input logic rclk_ind
);

    logic [2:0] age_q;
    logic       both_sel;
    logic       warm;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age_q <= '0;
        end else if (age_q != 3'd7) begin
            age_q <= age_q + 3'd1;
        end
    end

    assign warm     = (age_q == 3'd7);
    assign both_sel = loop_en ? (loop_pos & loop_neg) : (pos_rail & neg_rail);

    AST_NRZ_NEEDS_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && nrz_out) |-> $past(rclk_ind, 5)); // R2

    AST_ERR_NEEDS_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && err_out) |-> $past(rclk_ind, 5)); // R4

    AST_BOTH_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && $past(both_sel, 5)) |-> err_out); // R6

    AST_LOOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (loop_en && !loop_pos && !loop_neg) |-> !rclk_ind); // R9

    AST_RESET_CLEAR: assert property (@(posedge clk)
        $past(!rst_n) |-> (!nrz_out && !err_out)); // R10

endmodule

bind hdb3_rx_decoder hdb3_rx_decoder_chk u_chk (.*);

// File: tb/hdb3_rx_decoder_bench.sv
`timescale 1ns/1ps
module hdb3_rx_decoder_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hdb3_mode = 1'b1;
    logic loop_en = 1'b0;
    logic pos_rail = 1'b0;
    logic neg_rail = 1'b0;
    logic loop_pos = 1'b0;
    logic loop_neg = 1'b0;
    logic nrz_out, err_out, rclk_ind;

    int checks = 0;
    int errors = 0;

    logic sp [0:1023];
    logic sn [0:1023];
    logic ed [0:1023];
    logic ee [0:1023];
    logic nb_bits [0:1023];
    int   nsym;
    int   nbits;

    always #4 clk = ~clk;

    hdb3_rx_decoder u_hdb3_rx_decoder (
        .clk(clk), .rst_n(rst_n), .hdb3_mode(hdb3_mode), .loop_en(loop_en),
        .pos_rail(pos_rail), .neg_rail(neg_rail), .loop_pos(loop_pos),
        .loop_neg(loop_neg), .nrz_out(nrz_out), .err_out(err_out),
        .rclk_ind(rclk_ind)
    );

    task automatic chk(input string tag, input int idx, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s idx=%0d actual=%0b expected=%0b", tag, idx, act, exp);
        end
    endtask

    task automatic drive(input logic p, input logic n, input logic lp, input logic ln);
        pos_rail = p; neg_rail = n; loop_pos = lp; loop_neg = ln;
    endtask

    // Fill the pipeline with both-rail marks, then reset: R10
    task automatic do_reset();
        @(negedge clk);
        drive(1'b1, 1'b1, 1'b1, 1'b1);
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        drive(1'b0, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        chk("R10 nrz", 0, nrz_out, 1'b0);
        chk("R10 err", 0, err_out, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Bench HDB3 encoder: nb_bits -> sp/sn, expected = input bits, no error.
    task automatic encode();
        logic last_pos = 1'b0;
        int   parity = 0;
        int   i = 0;
        nsym = 0;
        while (i < nbits) begin
            if (i + 3 < nbits && !nb_bits[i] && !nb_bits[i+1] && !nb_bits[i+2] && !nb_bits[i+3]) begin
                if (parity % 2 == 1) begin
                    for (int k = 0; k < 3; k++) begin sp[nsym] = 0; sn[nsym] = 0; nsym++; end
                    sp[nsym] = last_pos; sn[nsym] = !last_pos; nsym++;
                end else begin
                    last_pos = !last_pos;
                    sp[nsym] = last_pos; sn[nsym] = !last_pos; nsym++;
                    for (int k = 0; k < 2; k++) begin sp[nsym] = 0; sn[nsym] = 0; nsym++; end
                    sp[nsym] = last_pos; sn[nsym] = !last_pos; nsym++;
                end
                parity = 0;
                for (int k = 0; k < 4; k++) begin ed[i+k] = 0; ee[i+k] = 0; end
                i += 4;
            end else begin
                if (nb_bits[i]) begin
                    last_pos = !last_pos;
                    sp[nsym] = last_pos; sn[nsym] = !last_pos;
                    parity++;
                end else begin
                    sp[nsym] = 0; sn[nsym] = 0;
                end
                ed[i] = nb_bits[i]; ee[i] = 0;
                nsym++; i++;
            end
        end
    endtask

    // Reference model of the requirements for hand-built streams.
    task automatic ref_model(input logic mode);
        int lp = 0;  // 0 none, 1 pos, 2 neg
        int lv = 0;
        for (int i = 0; i < nsym; i++) begin
            logic mk, bt;
            int   pol;
            mk = sp[i] | sn[i];
            bt = sp[i] & sn[i];
            ed[i] = mk; ee[i] = bt;
            if (mk && !bt) begin
                pol = sp[i] ? 1 : 2;
                if (lp == pol) begin
                    if (mode) begin
                        if (lv == pol) ee[i] = 1;
                        if (i >= 4 && (sp[i-4] | sn[i-4]) && !(sp[i-1] | sn[i-1]) && !(sp[i-2] | sn[i-2]))
                            for (int k = 0; k < 4; k++) ed[i-k] = 0;
                    end else begin
                        ee[i] = 1;
                    end
                    lv = pol;
                end
                lp = pol;
            end
        end
    endtask

    task automatic load_str(input string s);
        nsym = s.len();
        for (int i = 0; i < nsym; i++) begin
            sp[i] = (s[i] == "P") || (s[i] == "B");
            sn[i] = (s[i] == "N") || (s[i] == "B");
        end
    endtask

    // Plays sp/sn; bit j-5 is due at the falling edge where symbol j is driven (R1).
    task automatic play(input logic lp_mode, input string tagd, input string tage);
        for (int j = 0; j < nsym + 5; j++) begin
            logic p, n;
            @(negedge clk);
            if (j >= 5) begin
                chk(tagd, j - 5, nrz_out, ed[j-5]);
                chk(tage, j - 5, err_out, ee[j-5]);
            end
            p = (j < nsym) ? sp[j] : 1'b0;
            n = (j < nsym) ? sn[j] : 1'b0;
            if (lp_mode) drive(1'b1, 1'b1, p, n);   // external rails held high, must be ignored: R9
            else         drive(p, n, 1'b0, 1'b0);
            #1;
            chk("R8 rclk", j, rclk_ind, p | n);
        end
    endtask

    task automatic build_valid();
        logic [15:0] lfsr = 16'hACE1;
        nbits = 0;
        nb_bits[nbits++] = 1;
        for (int i = 0; i < 16; i++) nb_bits[nbits++] = 1;
        for (int i = 0; i < 21; i++) nb_bits[nbits++] = 0;
        for (int i = 0; i < 16; i++) nb_bits[nbits++] = (i % 2 == 0);
        for (int i = 0; i < 24; i++) nb_bits[nbits++] = ((i % 4) < 2);
        for (int i = 0; i < 24; i++) nb_bits[nbits++] = ((i % 5) == 0);
        for (int i = 0; i < 300; i++) begin
            nb_bits[nbits++] = lfsr[0] & (lfsr[3] | lfsr[7]);
            lfsr = {lfsr[0] ^ lfsr[2] ^ lfsr[3] ^ lfsr[5], lfsr[15:1]};
        end
        for (int i = 0; i < 6; i++) nb_bits[nbits++] = 0;
        encode();
    endtask

    initial begin
        #(200000 * 8);
        errors++; checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        drive(1'b0, 1'b0, 1'b0, 1'b0);
        repeat (3) @(negedge clk);
        chk("R10 nrz at start", 0, nrz_out, 1'b0);
        chk("R10 err at start", 0, err_out, 1'b0);
        rst_n = 1'b1;

        // R1: a single pulse shows up on exactly the fifth falling edge.
        do_reset();
        @(negedge clk); drive(1'b1, 1'b0, 1'b0, 1'b0);
        for (int c = 1; c <= 6; c++) begin
            @(negedge clk); drive(1'b0, 1'b0, 1'b0, 1'b0);
            chk("R1 latency nrz", c, nrz_out, c == 5);
            chk("R10 first pulse no err", c, err_out, 1'b0);
        end

        // R2, R4: valid HDB3 stream from the bench encoder.
        hdb3_mode = 1'b1; loop_en = 1'b0;
        do_reset();
        build_valid();
        play(1'b0, "R2 valid nrz", "R4 valid err");

        // R3, R4: substitutions B000V / BB00V and a repeated-polarity violation.
        do_reset();
        load_str("P000PN00NPN00N0P0000");
        ref_model(1'b1);
        play(1'b0, "R3 subst nrz", "R4 repeat err");

        // R5, R6: violations outside the window pattern, double-rail samples.
        do_reset();
        load_str("PP0NN0B0BNP0000PB00P0N000NN0000");
        ref_model(1'b1);
        play(1'b0, "R5 bad viol nrz", "R6 both err");

        // R7: AMI mode, every violation flagged, nothing zeroed.
        hdb3_mode = 1'b0;
        do_reset();
        load_str("PN0PP0NB0N00N0000P000PN00N0000");
        ref_model(1'b0);
        play(1'b0, "R7 ami nrz", "R7 ami err");

        // R9: loop test carries a valid stream, external rails stuck high.
        hdb3_mode = 1'b1; loop_en = 1'b1;
        do_reset();
        build_valid();
        play(1'b1, "R9 loop nrz", "R9 loop err");
        loop_en = 1'b0;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule